// File: doc/BRIEF.md
# Pulse Sequencer Run-Control State Machine

This block decides when a programmable pulse-pattern sequencer executes. It takes single-cycle software commands (stop, start, arm, continue, program), two asynchronous hardware inputs (an active-low falling-edge trigger and an active-low level reset), and three strobes from the instruction stepper. The strobes mark a STOP opcode reached, a WAIT opcode reached, and the start of the instruction that comes just before a WAIT. From these it keeps the run state and drives a run enable, a one-cycle rewind pulse and a one-cycle resume pulse for the stepper.

The states are UNINIT (after power-on), STOPPED (halted, not armed), ARMED (halted, armed), START_DLY (a start is counting its fixed latency), RUNNING, WAITING (paused by a WAIT opcode) and RESUME_DLY (a resume is counting its latency). The transitions are:

- power-on → UNINIT
- any state → ARMED on a hardware reset or a software arm
- any state → STOPPED on a software stop or program
- any state → START_DLY on a software start
- ARMED → START_DLY on a trigger edge
- WAITING → RESUME_DLY on a trigger edge or a software continue
- START_DLY / RESUME_DLY → RUNNING when the delay has run out
- RUNNING → STOPPED on a STOP opcode
- RUNNING → WAITING on a WAIT opcode, unless a trigger was stored while the instruction before that WAIT was executing, in which case RUNNING stays RUNNING and a resume pulse is issued.

The trigger is ignored in STOPPED, so after a STOP opcode the block needs a hardware reset or a software start before it can run again.

Top module: `seq_run_ctrl`

## Requirements
- R1: After the synchronous system reset `rst_n`, `state_o` is UNINIT (code 0) and `run_en_o`, `rewind_o` and `resume_o` are low. In UNINIT a trigger edge has no effect.
- R2: In RUNNING (code 4), a STOP-opcode strobe moves the block to STOPPED (code 1) on the next edge, with `run_en_o` low.
- R3: In STOPPED, falling edges on `hw_trig_n` have no effect. A software start (code 1) still starts execution.
- R4: `hw_rst_n` passes through a `SYNC_STAGES` flop synchronizer. Once the last stage holds low, the next edge puts the block in ARMED (code 2) from any state. `rewind_o` pulses for one cycle when ARMED is entered from another state. Trigger edges are ignored for as long as the reset is held low.
- R5: In ARMED, a falling edge on `hw_trig_n` leads to START_DLY (code 3), with `rewind_o` pulsed on entry. `run_en_o` rises `START_LAT` edges after the edge on which the last synchronizer stage captures the low level.
- R6: In WAITING (code 5), a falling trigger edge leads to RESUME_DLY (code 6) with no rewind. `run_en_o` and a one-cycle `resume_o` rise `RESUME_LAT` edges after the last synchronizer stage captures the low level.
- R7: Software commands are sampled when `cmd_vld_i` is high. Code 0 (stop) and code 4 (program) go to STOPPED. Code 2 (arm) goes to ARMED. Code 1 (start) goes to START_DLY with `rewind_o` from any state, and `run_en_o` rises `START_LAT` edges after the sampling edge. Code 3 (continue) from WAITING goes to RESUME_DLY, and `run_en_o` rises `RESUME_LAT` edges after the sampling edge.
- R8: When the synchronized hardware reset is active in the same cycle as a software command, the reset wins and the block goes to ARMED.
- R9: If `hw_trig_n` is already low when the block enters ARMED, that counts as a falling edge and the start sequence begins on the next edge.
- R10: A trigger edge (or a software continue) that arrives in RUNNING after the pre-WAIT strobe `win_open_i` is stored. When the WAIT strobe follows, the block stays RUNNING and pulses `resume_o` on the next edge. The stored trigger is used up by that WAIT.
- R11: A trigger edge that arrives in RUNNING before the pre-WAIT strobe is discarded, so a later WAIT still moves the block to WAITING.
- R12: A software continue outside WAITING and outside the pre-WAIT window has no effect. So do opcode strobes outside RUNNING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| hw_trig_n | input | 1 | Asynchronous hardware trigger, acts on its falling edge |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| cmd_vld_i | input | 1 | Software command strobe, one cycle |
| cmd_op_i | input | 3 | Command code: 0 stop, 1 start, 2 arm, 3 continue, 4 program |
| op_stop_i | input | 1 | Stepper reached a STOP opcode |
| op_wait_i | input | 1 | Stepper reached a WAIT opcode |
| win_open_i | input | 1 | Stepper began the instruction just before a WAIT |
| state_o | output | 3 | Current state code |
| run_en_o | output | 1 | Stepper may execute |
| rewind_o | output | 1 | One-cycle pulse: return to the first instruction |
| resume_o | output | 1 | One-cycle pulse: continue past a WAIT |

## Verification
The bench keeps the default parameters: a two-stage synchronizer, a start latency of 8 and a resume latency of 6. With these values the two launch delays differ by two cycles, so a check sampled at the wrong cycle or a swapped delay load shows up as a state or run-enable mismatch. The two-stage synchronizer also fixes the edge on which hardware resets and trigger edges take effect. This lets the bench place a software command exactly in the cycle where the reset acts, and a trigger exactly inside the pre-WAIT window.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;

    typedef enum logic [2:0] {
        RS_UNINIT     = 3'd0,
        RS_STOPPED    = 3'd1,
        RS_ARMED      = 3'd2,
        RS_START_DLY  = 3'd3,
        RS_RUNNING    = 3'd4,
        RS_WAITING    = 3'd5,
        RS_RESUME_DLY = 3'd6
    } run_state_e;

    typedef enum logic [2:0] {
        CMD_STOP  = 3'd0,
        CMD_START = 3'd1,
        CMD_ARM   = 3'd2,
        CMD_CONT  = 3'd3,
        CMD_PROG  = 3'd4
    } sw_cmd_e;

endpackage

// File: rtl/seq_in_sync.sv
// Multi-flop synchronizer for an active-low asynchronous input; idles high.
module seq_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], pin_i};
    end

    assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/seq_fall_det.sv
// Falling-edge detector; rearm_i forces the history to high so a low level
// seen on the next cycle counts as a fresh edge.
module seq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rearm_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       prev_q <= 1'b1;
        else if (rearm_i) prev_q <= 1'b1;
        else              prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/seq_dly_ctr.sv
// Down counter for launch latency; zero_o flags the last delay cycle.
module seq_dly_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         en_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load_i)             cnt_q <= load_val_i;
        else if (en_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
    import seq_run_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int START_LAT   = 8,
    parameter int RESUME_LAT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_trig_n,
    input  logic       hw_rst_n,
    input  logic       cmd_vld_i,
    input  logic [2:0] cmd_op_i,
    input  logic       op_stop_i,
    input  logic       op_wait_i,
    input  logic       win_open_i,
    output logic [2:0] state_o,
    output logic       run_en_o,
    output logic       rewind_o,
    output logic       resume_o
);
    localparam int MAX_LAT = (START_LAT > RESUME_LAT) ? START_LAT : RESUME_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);
    // Hardware paths already spent one cycle in the edge stage.
    localparam logic [CW-1:0] LD_HW_START = CW'(START_LAT - 2);
    localparam logic [CW-1:0] LD_SW_START = CW'(START_LAT - 1);
    localparam logic [CW-1:0] LD_HW_RES   = CW'(RESUME_LAT - 2);
    localparam logic [CW-1:0] LD_SW_RES   = CW'(RESUME_LAT - 1);

    run_state_e    state_q, nxt;
    logic          trig_lvl, rst_lvl, trig_fall, rst_act;
    logic          rearm, dly_zero, dly_load;
    logic [CW-1:0] dly_val;
    logic          rewind_evt, resume_evt, pend_set;
    logic          win_q, pend_q, win_act, win_clr;

    seq_in_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(hw_trig_n), .level_o(trig_lvl)
    );
    seq_in_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(hw_rst_n), .level_o(rst_lvl)
    );
    seq_fall_det u_trig_edge (
        .clk(clk), .rst_n(rst_n), .level_i(trig_lvl), .rearm_i(rearm), .fall_o(trig_fall)
    );
    seq_dly_ctr #(.W(CW)) u_dly (
        .clk(clk), .rst_n(rst_n), .load_i(dly_load), .load_val_i(dly_val),
        .en_i(state_q == RS_START_DLY || state_q == RS_RESUME_DLY), .zero_o(dly_zero)
    );

    assign rst_act = ~rst_lvl;
    assign win_act = win_q | win_open_i;

    // Next state: hardware reset > software command > opcode strobes > trigger.
    always_comb begin
        nxt        = state_q;
        dly_load   = 1'b0;
        dly_val    = '0;
        rewind_evt = 1'b0;
        resume_evt = 1'b0;
        pend_set   = 1'b0;
        if (rst_act) begin
            nxt = RS_ARMED;
        end else if (cmd_vld_i) begin
            case (cmd_op_i)
                CMD_STOP, CMD_PROG: nxt = RS_STOPPED;
                CMD_ARM:            nxt = RS_ARMED;
                CMD_START: begin
                    nxt        = RS_START_DLY;
                    dly_load   = 1'b1;
                    dly_val    = LD_SW_START;
                    rewind_evt = 1'b1;
                end
                CMD_CONT: begin
                    if (state_q == RS_WAITING) begin
                        nxt      = RS_RESUME_DLY;
                        dly_load = 1'b1;
                        dly_val  = LD_SW_RES;
                    end else if (state_q == RS_RUNNING && win_act) begin
                        pend_set = 1'b1;
                    end
                end
                default: nxt = state_q;
            endcase
        end else begin
            unique case (state_q)
                RS_RUNNING: begin
                    if (op_stop_i) begin
                        nxt = RS_STOPPED;
                    end else if (op_wait_i) begin
                        if (pend_q) resume_evt = 1'b1;
                        else        nxt = RS_WAITING;
                    end else if (trig_fall && win_act) begin
                        pend_set = 1'b1;
                    end
                end
                RS_ARMED: begin
                    if (trig_fall) begin
                        nxt        = RS_START_DLY;
                        dly_load   = 1'b1;
                        dly_val    = LD_HW_START;
                        rewind_evt = 1'b1;
                    end
                end
                RS_WAITING: begin
                    if (trig_fall) begin
                        nxt      = RS_RESUME_DLY;
                        dly_load = 1'b1;
                        dly_val  = LD_HW_RES;
                    end
                end
                RS_START_DLY: begin
                    if (dly_zero) nxt = RS_RUNNING;
                end
                RS_RESUME_DLY: begin
                    if (dly_zero) begin
                        nxt        = RS_RUNNING;
                        resume_evt = 1'b1;
                    end
                end
                RS_UNINIT, RS_STOPPED: nxt = state_q;
                default:               nxt = state_q;
            endcase
        end
        if (nxt == RS_ARMED && state_q != RS_ARMED) rewind_evt = 1'b1;
    end

    assign rearm   = (nxt == RS_ARMED) && (state_q != RS_ARMED);
    assign win_clr = (nxt != RS_RUNNING) || op_wait_i || op_stop_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_UNINIT;
        else        state_q <= nxt;
    end

    // Pre-WAIT window and stored trigger
    always_ff @(posedge clk) begin
        if (!rst_n || win_clr) begin
            win_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (win_open_i) win_q  <= 1'b1;
            if (pend_set)   pend_q <= 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en_o <= 1'b0;
            rewind_o <= 1'b0;
            resume_o <= 1'b0;
        end else begin
            run_en_o <= (nxt == RS_RUNNING);
            rewind_o <= rewind_evt;
            resume_o <= resume_evt;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/seq_run_ctrl_chk.sv
module seq_run_ctrl_chk
    import seq_run_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst_act,
    input logic       cmd_vld_i,
    input logic [2:0] cmd_op_i,
    input logic       op_stop_i,
    input logic [2:0] state_o,
    input logic       run_en_o,
    input logic       rewind_o,
    input logic       resume_o
);
    AST_UNINIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_act && !cmd_vld_i && state_o == RS_UNINIT) |=> state_o == RS_UNINIT); // R1
    AST_STOP_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_act && !cmd_vld_i && state_o == RS_RUNNING && op_stop_i)
        |=> (state_o == RS_STOPPED && !run_en_o)); // R2
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_act && !cmd_vld_i && state_o == RS_STOPPED) |=> state_o == RS_STOPPED); // R3
    AST_HWRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst_act |=> state_o == RS_ARMED); // R4
    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> run_en_o); // R6
    AST_SW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_act && cmd_vld_i && cmd_op_i == CMD_START)
        |=> (state_o == RS_START_DLY && rewind_o)); // R7
    AST_RST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rst_act && cmd_vld_i) |=> (state_o == RS_ARMED && !run_en_o)); // R8
endmodule

bind seq_run_ctrl seq_run_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hw_rst_act(rst_act), .cmd_vld_i(cmd_vld_i),
    .cmd_op_i(cmd_op_i), .op_stop_i(op_stop_i), .state_o(state_o),
    .run_en_o(run_en_o), .rewind_o(rewind_o), .resume_o(resume_o)
);

// File: tb/sim_seq_run_ctrl.sv
module sim_seq_run_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_trig_n = 1'b1, hw_rst_n = 1'b1;
    logic       cmd_vld_i = 1'b0;
    logic [2:0] cmd_op_i = 3'd0;
    logic       op_stop_i = 1'b0, op_wait_i = 1'b0, win_open_i = 1'b0;
    logic [2:0] state_o;
    logic       run_en_o, rewind_o, resume_o;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    seq_run_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hw_trig_n(hw_trig_n), .hw_rst_n(hw_rst_n),
        .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i), .op_stop_i(op_stop_i),
        .op_wait_i(op_wait_i), .win_open_i(win_open_i), .state_o(state_o),
        .run_en_o(run_en_o), .rewind_o(rewind_o), .resume_o(resume_o)
    );

    // state codes: 0 UNINIT 1 STOPPED 2 ARMED 3 START_DLY 4 RUNNING 5 WAITING 6 RESUME_DLY
    typedef struct packed {
        logic       vld;
        logic [2:0] op;
        logic       stp;
        logic       wt;
        logic [3:0] idle;
        logic [2:0] st;
        logic       run;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd4, 1'b0, 1'b0, 4'd0, 3'd1, 1'b0},  // R7 program
        '{1'b1, 3'd2, 1'b0, 1'b0, 4'd0, 3'd2, 1'b0},  // R7 arm
        '{1'b1, 3'd1, 1'b0, 1'b0, 4'd6, 3'd3, 1'b0},  // R7 start, still delaying
        '{1'b0, 3'd0, 1'b0, 1'b0, 4'd1, 3'd4, 1'b1},  // R7 run after START_LAT
        '{1'b0, 3'd0, 1'b0, 1'b1, 4'd0, 3'd5, 1'b0},  // R6 wait opcode
        '{1'b1, 3'd3, 1'b0, 1'b0, 4'd4, 3'd6, 1'b0},  // R7 continue delaying
        '{1'b0, 3'd0, 1'b0, 1'b0, 4'd1, 3'd4, 1'b1},  // R7 run after RESUME_LAT
        '{1'b0, 3'd0, 1'b1, 1'b0, 4'd0, 3'd1, 1'b0},  // R2 stop opcode
        '{1'b1, 3'd3, 1'b0, 1'b0, 4'd0, 3'd1, 1'b0},  // R12 continue ignored
        '{1'b0, 3'd0, 1'b0, 1'b1, 4'd0, 3'd1, 1'b0},  // R12 opcode ignored
        '{1'b1, 3'd2, 1'b0, 1'b0, 4'd0, 3'd2, 1'b0},  // R7 arm
        '{1'b1, 3'd4, 1'b0, 1'b0, 4'd0, 3'd1, 1'b0},  // R7 program stops
        '{1'b1, 3'd1, 1'b0, 1'b0, 4'd8, 3'd4, 1'b1},  // R3 sw start from stopped
        '{1'b1, 3'd1, 1'b0, 1'b0, 4'd0, 3'd3, 1'b0},  // R7 restart while running
        '{1'b1, 3'd0, 1'b0, 1'b0, 4'd0, 3'd1, 1'b0}   // R7 stop
    };

    function automatic string row_req(int i);
        case (i)
            4:       return "R6";
            7:       return "R2";
            8, 9:    return "R12";
            12:      return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(logic [2:0] op);
        cmd_vld_i = 1'b1; cmd_op_i = op;
        tick(1);
        cmd_vld_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1", "state", state_o, 0);
        check("R1", "run_en", run_en_o, 0);
        check("R1", "rewind", rewind_o, 0);
        check("R1", "resume", resume_o, 0);
        hw_trig_n = 1'b0; tick(3); hw_trig_n = 1'b1; tick(10);
        check("R1", "state after trigger in UNINIT", state_o, 0);
        check("R1", "run_en after trigger in UNINIT", run_en_o, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cmd_vld_i = TBL[i].vld; cmd_op_i = TBL[i].op;
            op_stop_i = TBL[i].stp; op_wait_i = TBL[i].wt;
            tick(1);
            cmd_vld_i = 1'b0; op_stop_i = 1'b0; op_wait_i = 1'b0;
            tick(int'(TBL[i].idle));
            check(row_req(i), $sformatf("table row %0d state", i), state_o, int'(TBL[i].st));
            check(row_req(i), $sformatf("table row %0d run_en", i), run_en_o, int'(TBL[i].run));
        end

        // R3 trigger ignored in STOPPED
        hw_trig_n = 1'b0; tick(3); hw_trig_n = 1'b1; tick(6);
        check("R3", "state after trigger in STOPPED", state_o, 1);

        // R4 hardware reset arms
        hw_rst_n = 1'b0; tick(3);
        check("R4", "state after hw reset", state_o, 2);
        check("R4", "rewind on arming", rewind_o, 1);
        tick(1);
        check("R4", "rewind one cycle", rewind_o, 0);
        hw_trig_n = 1'b0; tick(12);
        check("R4", "trigger ignored under reset", state_o, 2);
        check("R4", "run_en under reset", run_en_o, 0);
        hw_trig_n = 1'b1; tick(3);
        // R8 reset beats software start
        send_cmd(3'd1);
        check("R8", "state with reset and start", state_o, 2);
        check("R8", "no rewind with reset held", rewind_o, 0);
        hw_rst_n = 1'b1; tick(4);
        check("R4", "armed after release", state_o, 2);

        // R5 hardware start
        hw_trig_n = 1'b0; tick(3);
        check("R5", "state after trigger", state_o, 3);
        check("R5", "rewind on start", rewind_o, 1);
        tick(6);
        check("R5", "run_en one cycle early", run_en_o, 0);
        tick(1);
        check("R5", "run_en at START_LAT", run_en_o, 1);
        check("R5", "state running", state_o, 4);
        hw_trig_n = 1'b1; tick(3);

        // R12 trigger while running, no window
        hw_trig_n = 1'b0; tick(3); hw_trig_n = 1'b1; tick(10);
        check("R12", "trigger ignored while running", state_o, 4);
        // R11 early trigger discarded: WAIT pauses
        win_open_i = 1'b1; tick(1); win_open_i = 1'b0;
        op_wait_i = 1'b1; tick(1); op_wait_i = 1'b0;
        check("R11", "state after WAIT", state_o, 5);

        // R6 hardware resume
        hw_trig_n = 1'b0; tick(3);
        check("R6", "state resuming", state_o, 6);
        check("R6", "no rewind on resume", rewind_o, 0);
        tick(4);
        check("R6", "run_en one cycle early", run_en_o, 0);
        tick(1);
        check("R6", "run_en at RESUME_LAT", run_en_o, 1);
        check("R6", "resume pulse", resume_o, 1);
        hw_trig_n = 1'b1; tick(1);
        check("R6", "resume one cycle", resume_o, 0);

        // R10 pre-trigger stored
        win_open_i = 1'b1; tick(1); win_open_i = 1'b0;
        hw_trig_n = 1'b0; tick(4); hw_trig_n = 1'b1;
        check("R10", "still running before WAIT", state_o, 4);
        op_wait_i = 1'b1; tick(1); op_wait_i = 1'b0;
        check("R10", "state at WAIT with stored trigger", state_o, 4);
        check("R10", "resume pulse at WAIT", resume_o, 1);
        tick(1);
        op_wait_i = 1'b1; tick(1); op_wait_i = 1'b0;
        check("R10", "stored trigger used up", state_o, 5);

        // R9 trigger low at arm time
        send_cmd(3'd0);
        check("R7", "stop from waiting", state_o, 1);
        hw_trig_n = 1'b0; tick(5);
        check("R3", "held trigger ignored in STOPPED", state_o, 1);
        send_cmd(3'd2);
        check("R9", "armed", state_o, 2);
        tick(1);
        check("R9", "held-low trigger starts", state_o, 3);
        tick(7);
        check("R9", "running after start latency", run_en_o, 1);
        hw_trig_n = 1'b1; tick(2);

        // R12 software continue while running, no window
        send_cmd(3'd3);
        check("R12", "continue ignored while running", state_o, 4);
        tick(2);
        check("R12", "run_en kept", run_en_o, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule